// File: doc/BRIEF.md
# Memory Error Interrupt Aggregator

This block sits beside a memory controller and gathers its error reports into one interrupt. Four kinds of error arrive as single-cycle pulses: correctable ECC errors, uncorrectable ECC errors, a multi-bit parity field and address errors. Each pulse sets a sticky bit in a cause register. Each bit can be masked by an enable register. A registered interrupt is the OR of the enabled cause bits, and a separate registered fatal flag covers every class except correctable errors.

For the two ECC classes, the block keeps the failing address and a multi-word data snapshot. Each class has its own capture, and the first error stays held until software clears its cause bit. Each class also has a saturating event counter. A one-bit parent summary register records that this block has raised its interrupt, so a top-level interrupt controller can poll it.

Software reaches all state through a 32-bit strobe interface with a 5-bit word address. Cause bits and the parent bit are cleared by writing ones to them.

Top module: `memerr_irq_agg`

## Requirements
- R1: After synchronous reset, every cause, enable, parent, counter and capture register reads zero, and `irq_o`, `fatal_o`, `sum_o` and `reg_rvalid_o` are low.
- R2: A pulse on an error input sets its cause bit on the next clock edge, and the bit stays set. The cause register is at address 0. Bit 0 is correctable, bit 1 is uncorrectable, bits 2 to 2+PAR_W-1 hold the parity field bit for bit, and bit 2+PAR_W is address error.
- R3: A write to address 0 clears each cause bit whose write-data bit is 1 and leaves the bits written 0 unchanged, so writing all ones clears every bit. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R4: The enable register is at address 1 and uses the same bit layout as the cause register. `irq_o` is high exactly one cycle after some bit is set in both cause and enable. Writing zero to the enable register masks every source.
- R5: `fatal_o` is high one cycle after any uncorrectable, parity or address-error cause bit is set, whatever the enable register holds. A correctable cause bit alone never raises it.
- R6: The parent summary bit is at bit 0 of address 2 and drives `sum_o`. It is set one cycle after `irq_o` is high, and writing 1 to it clears it. If `irq_o` is high in the same cycle, setting wins over clearing.
- R7: A correctable pulse captures `ev_addr_i` (read at address 3) and the NWORDS data words (word i read at address 16+i, word i taken from bits 32i+31:32i of `ev_data_i`). The capture happens only when the correctable cause bit is clear or is being cleared in that cycle. Otherwise the earlier capture is held.
- R8: Uncorrectable errors have their own capture under the same rule: the address is at address 4 and word i is at address 24+i. Correctable events never disturb it.
- R9: Four event counters sit at addresses 5 to 8, for correctable, uncorrectable, parity and address errors in that order. Each counts the cycles in which its event is present. A cycle with any parity bit set counts once.
- R10: Each counter stops at 2^CNT_W-1 and never wraps.
- R11: A read strobe returns the addressed register on `reg_rdata_o`, with `reg_rvalid_o` high, on the following cycle. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_corr_i | input | 1 | Correctable ECC error pulse |
| ev_uncorr_i | input | 1 | Uncorrectable ECC error pulse |
| ev_par_i | input | PAR_W | Parity error field pulses |
| ev_addr_err_i | input | 1 | Address error pulse |
| ev_addr_i | input | ADDR_W | Failing word address accompanying an ECC pulse |
| ev_data_i | input | NWORDS*32 | Failing data words accompanying an ECC pulse |
| reg_addr_i | input | 5 | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| irq_o | output | 1 | Registered interrupt to the parent controller |
| fatal_o | output | 1 | Registered fatal-condition flag |
| sum_o | output | 1 | Parent summary bit |

## Verification
The assertions assume that address and data are valid in the same cycle as an ECC pulse. They also assume that reset is held for at least one edge before any event or strobe, and that no read and write target the same register in one cycle. The stimulus drives every input on the falling edge. It raises address and data only together with their pulse, and it issues reads and writes in separate cycles. The only deliberate overlap is a cause clear in the same cycle as a correctable event, which exercises the set-wins rule.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] RA_CAUSE   = 5'd0;
  localparam logic [REG_AW-1:0] RA_ENABLE  = 5'd1;
  localparam logic [REG_AW-1:0] RA_PARENT  = 5'd2;
  localparam logic [REG_AW-1:0] RA_CE_ADDR = 5'd3;
  localparam logic [REG_AW-1:0] RA_UE_ADDR = 5'd4;
  localparam logic [REG_AW-1:0] RA_CNT0    = 5'd5;
  // data word windows: 16..23 correctable, 24..31 uncorrectable
  localparam logic [1:0] WIN_CE = 2'b10;
  localparam logic [1:0] WIN_UE = 2'b11;
  localparam int NCLASS = 4;
endpackage

// File: rtl/memerr_cause.sv
module memerr_cause #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] set_i,
  input  logic [CW-1:0] clr_i,
  output logic [CW-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q & ~clr_i) | set_i;
  end

  for (genvar b = 0; b < CW; b++) begin : g_chk
    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> cause_q[b]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !cause_q[b]);
  end
endmodule

// File: rtl/memerr_satcnt.sv
module memerr_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) |=> (cnt_q == TOP));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (inc_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture #(
  parameter int AW = 20,
  parameter int DW = 160
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end
endmodule

// File: rtl/memerr_irq_agg.sv
module memerr_irq_agg
  import memerr_pkg::*;
#(
  parameter int PAR_W  = 2,
  parameter int ADDR_W = 20,
  parameter int NWORDS = 5,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ev_corr_i,
  input  logic                   ev_uncorr_i,
  input  logic [PAR_W-1:0]       ev_par_i,
  input  logic                   ev_addr_err_i,
  input  logic [ADDR_W-1:0]      ev_addr_i,
  input  logic [NWORDS*32-1:0]   ev_data_i,
  input  logic [REG_AW-1:0]      reg_addr_i,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic                   reg_rvalid_o,
  output logic                   irq_o,
  output logic                   fatal_o,
  output logic                   sum_o
);
  localparam int CW = PAR_W + 3;
  localparam int DW = NWORDS * 32;
  localparam logic [CW-1:0] FATAL_MASK = {{(CW-1){1'b1}}, 1'b0};

  logic [CW-1:0]    ev_vec, clr_vec, cause_q, en_q;
  logic             sum_q;
  logic [ADDR_W-1:0] ce_addr, ue_addr;
  logic [DW-1:0]    ce_data, ue_data;
  logic [NCLASS-1:0] cls_inc;
  logic [CNT_W-1:0] cnt [NCLASS];
  logic [31:0]      rd_mux;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:CW];

  assign ev_vec  = {ev_addr_err_i, ev_par_i, ev_uncorr_i, ev_corr_i};
  assign clr_vec = (reg_wr_i && reg_addr_i == RA_CAUSE) ? reg_wdata_i[CW-1:0] : '0;
  assign cls_inc = {ev_addr_err_i, |ev_par_i, ev_uncorr_i, ev_corr_i};

  memerr_cause #(.CW(CW)) u_cause (
    .clk(clk), .rst(rst), .set_i(ev_vec), .clr_i(clr_vec), .cause_q(cause_q)
  );

  memerr_capture #(.AW(ADDR_W), .DW(DW)) u_cap_ce (
    .clk(clk), .rst(rst),
    .take_i(ev_corr_i && (!cause_q[0] || clr_vec[0])),
    .addr_i(ev_addr_i), .data_i(ev_data_i),
    .addr_q(ce_addr), .data_q(ce_data)
  );

  memerr_capture #(.AW(ADDR_W), .DW(DW)) u_cap_ue (
    .clk(clk), .rst(rst),
    .take_i(ev_uncorr_i && (!cause_q[1] || clr_vec[1])),
    .addr_i(ev_addr_i), .data_i(ev_data_i),
    .addr_q(ue_addr), .data_q(ue_data)
  );

  for (genvar g = 0; g < NCLASS; g++) begin : g_cnt
    memerr_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc_i(cls_inc[g]), .cnt_q(cnt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      irq_o   <= 1'b0;
      fatal_o <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == RA_ENABLE) en_q <= reg_wdata_i[CW-1:0];
      irq_o   <= |(cause_q & en_q);
      fatal_o <= |(cause_q & FATAL_MASK);
      sum_q   <= (sum_q & ~(reg_wr_i && reg_addr_i == RA_PARENT && reg_wdata_i[0]))
                 | irq_o;
    end
  end
  assign sum_o = sum_q;

  always_comb begin
    logic [7:0] base;
    base   = {reg_addr_i[2:0], 5'b0};
    rd_mux = '0;
    if (reg_addr_i[4:3] == WIN_CE && int'(reg_addr_i[2:0]) < NWORDS)
      rd_mux = ce_data[base +: 32];
    else if (reg_addr_i[4:3] == WIN_UE && int'(reg_addr_i[2:0]) < NWORDS)
      rd_mux = ue_data[base +: 32];
    else begin
      case (reg_addr_i)
        RA_CAUSE:   rd_mux = 32'(cause_q);
        RA_ENABLE:  rd_mux = 32'(en_q);
        RA_PARENT:  rd_mux = {31'b0, sum_q};
        RA_CE_ADDR: rd_mux = 32'(ce_addr);
        RA_UE_ADDR: rd_mux = 32'(ue_addr);
        default: begin
          for (int k = 0; k < NCLASS; k++)
            if (reg_addr_i == RA_CNT0 + REG_AW'(k)) rd_mux = 32'(cnt[k]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) reg_rdata_o <= rd_mux;
    end
  end

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !(|(cause_q & en_q)) |=> !irq_o);
  assert_fatal_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (|(cause_q & FATAL_MASK)) |=> fatal_o);
  assert_parent_follows_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> sum_o);
  assert_ce_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cause_q[0] && !clr_vec[0]) |=> $stable(ce_addr));
  assert_ue_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cause_q[1] && !clr_vec[1]) |=> ($stable(ue_addr) && $stable(ue_data)));
  assert_read_valid_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rvalid_o);
endmodule

// File: tb/memerr_irq_agg_test.sv
module memerr_irq_agg_test;
  localparam int PAR_W = 2, ADDR_W = 20, NWORDS = 5, CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_corr_i = 0, ev_uncorr_i = 0, ev_addr_err_i = 0;
  logic [PAR_W-1:0] ev_par_i = '0;
  logic [ADDR_W-1:0] ev_addr_i = '0;
  logic [NWORDS*32-1:0] ev_data_i = '0;
  logic [4:0] reg_addr_i = '0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic reg_rvalid_o, irq_o, fatal_o, sum_o;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  memerr_irq_agg #(.PAR_W(PAR_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .ev_corr_i(ev_corr_i), .ev_uncorr_i(ev_uncorr_i),
    .ev_par_i(ev_par_i), .ev_addr_err_i(ev_addr_err_i), .ev_addr_i(ev_addr_i),
    .ev_data_i(ev_data_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .reg_rvalid_o(reg_rvalid_o), .irq_o(irq_o), .fatal_o(fatal_o), .sum_o(sum_o)
  );

  function automatic logic [31:0] word(input logic [23:0] seed, input int i);
    return {seed, 8'(i)};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && reg_rvalid_o) begin
      if (exp_q.size() == 0) check(reg_rdata_o, 32'hDEAD_0000, "R11 unexpected read data");
      else check(reg_rdata_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd_i = 1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 0;
  endtask

  task automatic set_data(input logic [23:0] seed);
    for (int i = 0; i < NWORDS; i++) ev_data_i[i*32 +: 32] = word(seed, i);
  endtask

  task automatic pulse(input logic c, input logic u, input logic [PAR_W-1:0] p,
                       input logic ae, input logic [ADDR_W-1:0] a, input logic [23:0] seed);
    ev_corr_i = c; ev_uncorr_i = u; ev_par_i = p; ev_addr_err_i = ae;
    ev_addr_i = a; set_data(seed);
    @(negedge clk);
    ev_corr_i = 0; ev_uncorr_i = 0; ev_par_i = '0; ev_addr_err_i = 0;
    ev_addr_i = '0; ev_data_i = '0;
  endtask

  task automatic rd_words(input logic [4:0] base, input logic [23:0] seed, input string tag);
    for (int i = 0; i < NWORDS; i++) rd(base + 5'(i), word(seed, i), tag);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    n_vec++; n_bad++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    check({29'b0, irq_o, fatal_o, sum_o}, 32'h0, "R1 outputs after reset");
    rd(5'd0, 32'h0, "R1 cause reset");
    rd(5'd1, 32'h0, "R1 enable reset");
    rd(5'd2, 32'h0, "R1 parent reset");
    rd(5'd5, 32'h0, "R1 counter reset");
    rd(5'd16, 32'h0, "R1 capture reset");

    // correctable with everything masked
    pulse(1, 0, 2'b00, 0, 20'h1_2345, 24'hA1A1A1);
    tick(1);
    check({31'b0, irq_o}, 32'h0, "R4 masked irq stays low");
    check({31'b0, fatal_o}, 32'h0, "R5 correctable not fatal");
    rd(5'd0, 32'h1, "R2 correctable cause bit0");
    rd(5'd3, 32'h1_2345, "R7 correctable address");
    rd_words(5'd16, 24'hA1A1A1, "R7 correctable data word");

    // second correctable must not overwrite
    pulse(1, 0, 2'b00, 0, 20'h0_0BAD, 24'hB2B2B2);
    rd(5'd3, 32'h1_2345, "R7 capture held");
    rd(5'd16, word(24'hA1A1A1, 0), "R7 data held");
    rd(5'd5, 32'd2, "R9 correctable count");

    // enable everything
    wr(5'd1, 32'h1F);
    tick(2);
    check({31'b0, irq_o}, 32'h1, "R4 irq after enable");
    check({31'b0, sum_o}, 32'h1, "R6 summary set");
    rd(5'd2, 32'h1, "R6 parent readback");

    // W1C clear of bit0
    wr(5'd0, 32'h1);
    rd(5'd0, 32'h0, "R3 write-one clears");
    tick(1);
    check({31'b0, irq_o}, 32'h0, "R4 irq drops after clear");
    check({31'b0, sum_o}, 32'h1, "R6 summary sticky");
    wr(5'd2, 32'h1);
    check({31'b0, sum_o}, 32'h0, "R6 summary write-one clear");

    // fresh capture after clear
    pulse(1, 0, 2'b00, 0, 20'h3_3333, 24'hC3C3C3);
    rd(5'd3, 32'h3_3333, "R7 recapture after clear");

    // uncorrectable
    pulse(0, 1, 2'b00, 0, 20'h4_4444, 24'hD4D4D4);
    tick(1);
    check({31'b0, fatal_o}, 32'h1, "R5 uncorrectable fatal");
    rd(5'd4, 32'h4_4444, "R8 uncorrectable address");
    rd_words(5'd24, 24'hD4D4D4, "R8 uncorrectable data word");
    rd(5'd3, 32'h3_3333, "R8 correctable capture untouched");
    rd(5'd0, 32'h3, "R2 two cause bits");

    // mask all, fatal independent of enable
    wr(5'd1, 32'h0);
    tick(1);
    check({31'b0, irq_o}, 32'h0, "R4 zero enable masks");
    check({31'b0, fatal_o}, 32'h1, "R5 fatal ignores enable");

    // parity and address errors
    pulse(0, 0, 2'b10, 0, '0, 24'h0);
    pulse(0, 0, 2'b11, 0, '0, 24'h0);
    pulse(0, 0, 2'b00, 1, '0, 24'h0);
    rd(5'd7, 32'd2, "R9 parity counts once per cycle");
    rd(5'd8, 32'd1, "R9 address error count");
    rd(5'd0, 32'h1F, "R2 full cause layout");

    // write zero changes nothing, all ones clears
    wr(5'd0, 32'h0);
    rd(5'd0, 32'h1F, "R3 write zero no effect");
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, 32'h0, "R3 all ones clears");
    tick(1);
    check({31'b0, fatal_o}, 32'h0, "R5 fatal clears");

    // set wins over clear in same cycle
    wr(5'd0, 32'h0);
    ev_corr_i = 1; ev_addr_i = 20'h5_5555; set_data(24'hE5E5E5);
    reg_wr_i = 1; reg_addr_i = 5'd0; reg_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr_i = 0; reg_wdata_i = '0; ev_corr_i = 0; ev_addr_i = '0; ev_data_i = '0;
    rd(5'd0, 32'h1, "R3 event beats clear");
    rd(5'd3, 32'h5_5555, "R7 capture on clearing cycle");

    // saturation
    for (int i = 0; i < 20; i++) pulse(0, 0, 2'b00, 1, '0, 24'h0);
    rd(5'd8, 32'd15, "R10 counter saturates");
    rd(5'd6, 32'd1, "R9 uncorrectable count");
    rd(5'd5, 32'd4, "R9 correctable total");
    rd(5'd31, 32'h0, "R11 unmapped reads zero");
    rd(5'd21, 32'h0, "R11 word beyond NWORDS reads zero");

    tick(3);
    check(32'(exp_q.size()), 32'h0, "R11 all reads returned");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule